// File: doc/BRIEF.md
# Formatless / I2C Slave Mode Switcher

This block is the mode-control front end of a serial port with two operating modes. In I2C-format slave mode the port belongs to an external slave engine. That engine is outside this block and reaches it only through its line-pull requests, an address-seen pulse and the address-wait flag. In formatless mode the port moves raw bytes on the shared SDA line. Those bytes are timed by a dedicated formatless clock input that is separate from SCL. Software enters formatless mode by writing 1 to a switch bit. It must set the direction bit to the wanted formatless direction beforehand, or in the same write.

The port leaves formatless mode by itself. When the block sees a falling edge on SCL while the switch bit is set, it returns the port to I2C slave mode at once, without waiting for a stop condition. In that same cycle it clears the switch bit and the direction bit and raises the address-wait flag, so the port is ready to receive a slave address. While formatless mode is active the block never pulls SCL low.

All three line inputs pass through two-flop synchronizers. Formatless bytes are 8 bits long and move MSB first. A byte that is only partly shifted when the switch happens is dropped.

Top module: `serial_mode_switch`

## Requirements
- R1: After reset the switch bit and the direction bit read 0 and the mode reads I2C (0). The address-wait flag reads 1, and neither SCL nor SDA is pulled low.
- R2: A register write with switch=1 made in I2C mode enters formatless mode on the next clock. The direction bit takes the value from the same write, and the address-wait flag clears.
- R3: While formatless mode is active, register writes have no effect: neither the switch bit nor the direction bit changes.
- R4: A high-to-low transition of SCL during formatless mode returns the port to I2C mode (mode reads 0) exactly three clocks after the pin changes, with no stop condition needed.
- R5: On that automatic return, the direction bit reads 0 and the address-wait flag reads 1.
- R6: SCL is never pulled low in formatless mode. In I2C mode the SCL pull-low output follows the slave engine's SCL request.
- R7: In I2C mode the SDA pull-low output follows the slave engine's SDA request. In formatless receive (direction 0), SDA is never pulled low.
- R8: In formatless receive, SDA is sampled on each rising edge of the formatless clock and bits are assembled MSB first. After the eighth sample, the byte appears on rxByte together with a one-clock byteDone pulse.
- R9: In formatless transmit (direction 1), txByte is loaded on entry and again after each completed byte. The MSB is presented first, and a bit of 0 pulls SDA low. The next bit appears after each falling edge of the formatless clock. byteDone pulses after the eighth falling edge.
- R10: A formatless byte cut short by the automatic return produces no byteDone. On the next entry, bit counting starts again from the first bit.
- R11: In I2C mode, a pulse on i2cAddrSeen clears the address-wait flag.
- R12: An SCL falling edge in I2C mode changes neither the direction bit nor the address-wait flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrSwitch | input | 1 | Switch bit value to write (1 = formatless) |
| regWrDir | input | 1 | Direction bit value to write (1 = transmit) |
| rdSwitch | output | 1 | Switch bit readback |
| rdDir | output | 1 | Direction bit readback |
| rdFmtMode | output | 1 | Current mode: 1 formatless, 0 I2C slave |
| rdAddrWait | output | 1 | Port waits for a slave address |
| i2cAddrSeen | input | 1 | Pulse from slave engine: address received |
| i2cSclLow | input | 1 | Slave engine request to pull SCL low |
| i2cSdaLow | input | 1 | Slave engine request to pull SDA low |
| sclIn | input | 1 | SCL pin level |
| sdaIn | input | 1 | SDA pin level |
| fmtClkIn | input | 1 | Dedicated formatless clock pin |
| sclDriveLow | output | 1 | Open-drain SCL pull-low enable |
| sdaDriveLow | output | 1 | Open-drain SDA pull-low enable |
| txByte | input | 8 | Byte to transmit in formatless mode |
| rxByte | output | 8 | Last byte received in formatless mode |
| byteDone | output | 1 | One-clock pulse at the end of each formatless byte |

## Verification
The assertions check on every cycle that SCL stays released and receive never drives SDA while formatless mode is active. They also check that the direction bit holds steady through formatless mode, that every drop of the switch bit follows a detected SCL fall and leaves direction 0 with address-wait set, and that byteDone never lasts more than one clock. The bench scenarios show the data paths and the timing. They sweep all 256 byte values through receive and through transmit, and measure the exact three-clock latency of the automatic switch. They also check that an aborted partial byte leaves no trace on the next entry, and that SCL edges and register writes are ignored in the mode where they must be.

// File: rtl/fmtsw_pkg.sv
`timescale 1ns/1ps
package fmtsw_pkg;

  // Strobes from the mode controller to the formatless datapath
  typedef struct packed {
    logic enterFmt;   // one-cycle: switch bit being set, load shifter
    logic abortByte;  // one-cycle: automatic return, drop partial byte
    logic fmtActive;  // level: formatless mode active
    logic txDir;      // level: 1 transmit, 0 receive
  } modeStrobes_t;

endpackage

// File: rtl/fmtsw_sync.sv
`timescale 1ns/1ps
module fmtsw_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] rawIn,
  output logic [W-1:0] syncOut
);

  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= rawIn;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/fmtsw_ctrl.sv
`timescale 1ns/1ps
module fmtsw_ctrl
  import fmtsw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic         wrSwitch,
  input  logic         wrDir,
  input  logic         sclSync,
  input  logic         i2cAddrSeen,
  output logic         switchBit,
  output logic         dirBit,
  output logic         addrWait,
  output logic         sclFall,
  output modeStrobes_t strobes
);

  logic sclPrev;
  logic autoExit;
  logic enterReq;

  always_ff @(posedge clk) begin
    if (!rstN) sclPrev <= 1'b1;
    else       sclPrev <= sclSync;
  end

  assign sclFall  = sclPrev & ~sclSync;
  assign autoExit = switchBit & sclFall;
  assign enterReq = regWrEn & wrSwitch & ~switchBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      switchBit <= 1'b0;
      dirBit    <= 1'b0;
      addrWait  <= 1'b1;
    end else if (autoExit) begin
      // return to slave mode, receive, wait for address
      switchBit <= 1'b0;
      dirBit    <= 1'b0;
      addrWait  <= 1'b1;
    end else begin
      if (regWrEn && !switchBit) begin
        switchBit <= wrSwitch;
        dirBit    <= wrDir;
      end
      if (!switchBit && (enterReq || i2cAddrSeen)) addrWait <= 1'b0;
    end
  end

  assign strobes.enterFmt  = enterReq;
  assign strobes.abortByte = autoExit;
  assign strobes.fmtActive = switchBit;
  assign strobes.txDir     = dirBit;

endmodule

// File: rtl/fmtsw_datapath.sv
`timescale 1ns/1ps
module fmtsw_datapath
  import fmtsw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  modeStrobes_t      strobes,
  input  logic              fclkSync,
  input  logic              sdaSync,
  input  logic [DATA_W-1:0] txByte,
  input  logic              i2cSdaLow,
  input  logic              i2cSclLow,
  output logic [DATA_W-1:0] rxByte,
  output logic              byteDone,
  output logic              sdaDriveLow,
  output logic              sclDriveLow
);

  localparam int               CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

  logic              fclkPrev;
  logic              fRise;
  logic              fFall;
  logic [DATA_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] shiftedIn;

  always_ff @(posedge clk) begin
    if (!rstN) fclkPrev <= 1'b0;
    else       fclkPrev <= fclkSync;
  end

  assign fRise     = ~fclkPrev & fclkSync;
  assign fFall     = fclkPrev & ~fclkSync;
  assign shiftedIn = {shiftReg[DATA_W-2:0], sdaSync};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      rxByte   <= '0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (strobes.enterFmt) begin
        shiftReg <= txByte;
        bitCnt   <= '0;
      end else if (strobes.abortByte || !strobes.fmtActive) begin
        bitCnt <= '0;
      end else if (!strobes.txDir && fRise) begin
        shiftReg <= shiftedIn;
        if (bitCnt == LAST) begin
          bitCnt   <= '0;
          rxByte   <= shiftedIn;
          byteDone <= 1'b1;
        end else begin
          bitCnt <= bitCnt + CNT_W'(1);
        end
      end else if (strobes.txDir && fFall) begin
        if (bitCnt == LAST) begin
          bitCnt   <= '0;
          shiftReg <= txByte;
          byteDone <= 1'b1;
        end else begin
          bitCnt   <= bitCnt + CNT_W'(1);
          shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sdaDriveLow = strobes.fmtActive ? (strobes.txDir & ~shiftReg[DATA_W-1]) : i2cSdaLow;
  assign sclDriveLow = strobes.fmtActive ? 1'b0 : i2cSclLow;

endmodule

// File: rtl/serial_mode_switch.sv
`timescale 1ns/1ps
module serial_mode_switch
  import fmtsw_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regWrSwitch,
  input  logic              regWrDir,
  output logic              rdSwitch,
  output logic              rdDir,
  output logic              rdFmtMode,
  output logic              rdAddrWait,
  input  logic              i2cAddrSeen,
  input  logic              i2cSclLow,
  input  logic              i2cSdaLow,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              fmtClkIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  input  logic [DATA_W-1:0] txByte,
  output logic [DATA_W-1:0] rxByte,
  output logic              byteDone
);

  logic [2:0]   pinSync;
  logic         switchBit;
  logic         dirBit;
  logic         addrWait;
  logic         sclFall;
  modeStrobes_t strobes;

  fmtsw_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   ({sclIn, sdaIn, fmtClkIn}),
    .syncOut (pinSync)
  );

  fmtsw_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .wrSwitch    (regWrSwitch),
    .wrDir       (regWrDir),
    .sclSync     (pinSync[2]),
    .i2cAddrSeen (i2cAddrSeen),
    .switchBit   (switchBit),
    .dirBit      (dirBit),
    .addrWait    (addrWait),
    .sclFall     (sclFall),
    .strobes     (strobes)
  );

  fmtsw_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .fclkSync    (pinSync[0]),
    .sdaSync     (pinSync[1]),
    .txByte      (txByte),
    .i2cSdaLow   (i2cSdaLow),
    .i2cSclLow   (i2cSclLow),
    .rxByte      (rxByte),
    .byteDone    (byteDone),
    .sdaDriveLow (sdaDriveLow),
    .sclDriveLow (sclDriveLow)
  );

  assign rdSwitch   = switchBit;
  assign rdDir      = dirBit;
  assign rdFmtMode  = switchBit;
  assign rdAddrWait = addrWait;

endmodule

// File: rtl/serial_mode_switch_chk.sv
`timescale 1ns/1ps
module serial_mode_switch_chk (
  input logic clk,
  input logic rstN,
  input logic rdSwitch,
  input logic rdDir,
  input logic rdFmtMode,
  input logic rdAddrWait,
  input logic sclDriveLow,
  input logic sdaDriveLow,
  input logic byteDone,
  input logic sclFallSeen
);

  p_scl_released_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdFmtMode |-> !sclDriveLow);

  p_rx_no_drive_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdFmtMode && !rdDir) |-> !sdaDriveLow);

  p_exit_on_scl_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdSwitch) |-> $past(sclFallSeen));

  p_exit_state_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdSwitch) |-> (!rdDir && rdAddrWait));

  p_dir_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdSwitch && $past(rdSwitch)) |-> $stable(rdDir));

  p_enter_clears_wait_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdSwitch) |-> !rdAddrWait);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |=> !byteDone);

endmodule

bind serial_mode_switch serial_mode_switch_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .rdSwitch    (rdSwitch),
  .rdDir       (rdDir),
  .rdFmtMode   (rdFmtMode),
  .rdAddrWait  (rdAddrWait),
  .sclDriveLow (sclDriveLow),
  .sdaDriveLow (sdaDriveLow),
  .byteDone    (byteDone),
  .sclFallSeen (sclFall)
);

// File: tb/serial_mode_switch_tb_top.sv
`timescale 1ns/1ps
module serial_mode_switch_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0, regWrSwitch = 1'b0, regWrDir = 1'b0;
  logic       rdSwitch, rdDir, rdFmtMode, rdAddrWait;
  logic       i2cAddrSeen = 1'b0, i2cSclLow = 1'b0, i2cSdaLow = 1'b0;
  logic       sclIn = 1'b1, sdaIn = 1'b1, fmtClkIn = 1'b0;
  logic       sclDriveLow, sdaDriveLow;
  logic [7:0] txByte = 8'h00;
  logic [7:0] rxByte;
  logic       byteDone;

  int checks = 0;
  int errors = 0;
  int doneCnt = 0;
  logic [7:0] lastRx = 8'h00;
  bit finished = 0;

  always #5 clk = ~clk;

  serial_mode_switch dut_i (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrSwitch(regWrSwitch), .regWrDir(regWrDir),
    .rdSwitch(rdSwitch), .rdDir(rdDir), .rdFmtMode(rdFmtMode), .rdAddrWait(rdAddrWait),
    .i2cAddrSeen(i2cAddrSeen), .i2cSclLow(i2cSclLow), .i2cSdaLow(i2cSdaLow),
    .sclIn(sclIn), .sdaIn(sdaIn), .fmtClkIn(fmtClkIn),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .txByte(txByte), .rxByte(rxByte), .byteDone(byteDone)
  );

  always @(posedge clk) begin
    if (rstN && byteDone) begin
      doneCnt = doneCnt + 1;
      lastRx  = rxByte;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic sw, input logic dir);
    regWrEn = 1'b1; regWrSwitch = sw; regWrDir = dir;
    tick(1);
    regWrEn = 1'b0; regWrSwitch = 1'b0; regWrDir = 1'b0;
  endtask

  task automatic sclPulse();
    sclIn = 1'b0; tick(3);
    sclIn = 1'b1; tick(3);
  endtask

  task automatic rxBits(input logic [7:0] b, input int nBits);
    for (int i = 7; i > 7 - nBits; i--) begin
      sdaIn = b[i]; tick(4);
      fmtClkIn = 1'b1; tick(4);
      fmtClkIn = 1'b0;
    end
    tick(4);
  endtask

  initial begin : watchdog
    #1500000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int startCnt;
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R1: reset state
    chk("R1 switch", rdSwitch, 0);
    chk("R1 dir", rdDir, 0);
    chk("R1 mode", rdFmtMode, 0);
    chk("R1 addrWait", rdAddrWait, 1);
    chk("R1 sclDrive", sclDriveLow, 0);
    chk("R1 sdaDrive", sdaDriveLow, 0);

    // R7 / R6: I2C mode passes engine requests through
    i2cSclLow = 1'b1; i2cSdaLow = 1'b1; #1;
    chk("R6 scl follows engine", sclDriveLow, 1);
    chk("R7 sda follows engine", sdaDriveLow, 1);

    // R11: address-seen clears wait flag in I2C mode
    i2cAddrSeen = 1'b1; tick(1); i2cAddrSeen = 1'b0;
    chk("R11 addrWait cleared", rdAddrWait, 0);

    // R12: SCL fall in I2C mode does nothing
    writeReg(1'b0, 1'b1);
    chk("R12 dir preset", rdDir, 1);
    sclPulse();
    chk("R12 dir kept", rdDir, 1);
    chk("R12 addrWait kept", rdAddrWait, 0);
    chk("R12 mode kept", rdFmtMode, 0);

    // R2: enter formatless receive
    writeReg(1'b1, 1'b0);
    chk("R2 mode", rdFmtMode, 1);
    chk("R2 dir", rdDir, 0);
    chk("R2 addrWait", rdAddrWait, 0);
    #1;
    chk("R6 scl released in fmt", sclDriveLow, 0);
    chk("R7 no sda drive in rx", sdaDriveLow, 0);

    // R3: writes ignored in formatless mode
    writeReg(1'b0, 1'b1);
    chk("R3 switch kept", rdSwitch, 1);
    chk("R3 dir kept", rdDir, 0);
    i2cSclLow = 1'b0; i2cSdaLow = 1'b0;

    // R8: receive sweep of all byte values
    for (int v = 0; v < 256; v++) begin
      startCnt = doneCnt;
      rxBits(v[7:0], 8);
      chk("R8 rx done count", doneCnt, startCnt + 1);
      chk("R8 rx byte", lastRx, v);
    end

    // R4/R5: exact latency of automatic switch
    sclIn = 1'b0; tick(2);
    chk("R4 still fmt at 2 clocks", rdSwitch, 1);
    tick(1);
    chk("R4 I2C at 3 clocks", rdSwitch, 0);
    chk("R4 mode", rdFmtMode, 0);
    chk("R5 dir", rdDir, 0);
    chk("R5 addrWait", rdAddrWait, 1);
    sclIn = 1'b1; tick(3);

    // R10: partial byte dropped, counter restarts
    writeReg(1'b1, 1'b0);
    startCnt = doneCnt;
    rxBits(8'hFF, 5);
    sclPulse();
    chk("R10 no done on abort", doneCnt, startCnt);
    chk("R10 back in I2C", rdFmtMode, 0);
    writeReg(1'b1, 1'b0);
    rxBits(8'hA5, 3);
    chk("R10 no early done", doneCnt, startCnt);
    rxBits(8'hA5 << 3, 5);
    chk("R10 full byte after restart", doneCnt, startCnt + 1);
    chk("R10 byte value", lastRx, 8'hA5);
    sclPulse();

    // R9: transmit sweep of all byte values
    for (int v = 0; v < 256; v++) begin
      txByte = v[7:0];
      writeReg(1'b1, 1'b1);
      chk("R9 tx mode", rdFmtMode, 1);
      chk("R9 tx dir", rdDir, 1);
      startCnt = doneCnt;
      for (int i = 7; i >= 0; i--) begin
        tick(2);
        chk("R9 tx bit", sdaDriveLow, !v[i]);
        chk("R6 scl released in tx", sclDriveLow, 0);
        fmtClkIn = 1'b1; tick(4);
        fmtClkIn = 1'b0; tick(4);
      end
      chk("R9 tx done", doneCnt, startCnt + 1);
      chk("R9 reload MSB", sdaDriveLow, !v[7]);
      sclPulse();
      chk("R5 tx exit dir", rdDir, 0);
      chk("R5 tx exit addrWait", rdAddrWait, 1);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule